// File: doc/BRIEF.md
# Phase Offset Recalibration Sequencer

This block is the control sequencer that realigns the output clocks of a digital PLL to its selected reference without disturbing the phase offset that software has programmed. Software starts it by writing 1 to a self-clearing control bit. The sequencer then asks the loop to freeze its frequency (a short holdover). It ramps the applied phase offset down to zero in bounded steps and fires a single reset strobe to every output clock divider. It then ramps the offset back up to the programmed value and releases the loop. The net phase offset seen at the outputs is the same before and after. A direct write of the offset, by contrast, steps the phase at once.

The ramp generator is part of this block. It moves the applied offset toward its current target by at most a programmed step on each update tick and never overshoots. The offset word is latched when a sequence starts, so writes made during a sequence only take effect after it has finished. Outside a sequence the applied offset simply follows the programmed word.

Top module: `phase_recal_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows busy, recal_bit, hold_req and div_rst at 0 and phase_ofs at 0. This also applies when a sequence is in progress.
- R2: When idle, phase_ofs equals the offset_reg value sampled at the previous clock edge, and hold_req is 0.
- R3: A write (recal_wr=1) of recal_wdata=1 while idle makes busy, recal_bit and hold_req 1 in the next cycle. A write of 0 while idle starts nothing.
- R4: During a sequence, phase_ofs (two's complement) moves toward the current target only at edges where tick=1. Each move is by min(distance, step), where step is step_size, or 1 when step_size is 0. It never passes the target and stays unchanged at edges where tick=0.
- R5: The first ramp ends at phase_ofs = 0. After that, div_rst is 1 for exactly one cycle per sequence, while hold_req is 1 and phase_ofs is 0.
- R6: After the divider reset, phase_ofs ramps to the captured offset. hold_req is high for every busy cycle except the last one. In that last cycle phase_ofs equals the captured offset.
- R7: recal_bit clears by itself when the sequence ends and always equals busy. With tick held at 1, a sequence is busy for 5 + ceil(|offset|/step) * 2 cycles.
- R8: Writes of either value to recal_wr while busy are ignored. They do not restart, shorten or extend the sequence, and no new sequence follows.
- R9: offset_reg is captured at the start edge. Changing it during a sequence does not change the second ramp's target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recal_wr | input | 1 | Write strobe for the recalibration control bit |
| recal_wdata | input | 1 | Value written to the control bit (1 = start) |
| offset_reg | input | OFS_W | Programmed phase offset, two's complement |
| step_size | input | STEP_W | Largest ramp change per tick (0 acts as 1) |
| tick | input | 1 | Ramp update tick |
| recal_bit | output | 1 | Control bit read-back, clears when done |
| busy | output | 1 | Sequence in progress |
| hold_req | output | 1 | Frequency-hold request to the loop |
| div_rst | output | 1 | One-cycle reset strobe for all output dividers |
| phase_ofs | output | OFS_W | Applied phase offset to the loop, two's complement |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. They check the one-cycle width of the divider strobe, and that the strobe only occurs at zero phase under hold. They also check that busy and the control bit agree and that hold never appears without busy. Finally they check that the ramp never moves by more than one step per tick and stays still without a tick. Other behaviour only shows over a whole sequence, so the bench scenarios cover it. This includes the exact sequence length for each offset and step, the single strobe per run, and the restored final offset. It also includes the ignored mid-run writes, the latched offset surviving a change of offset_reg, and the stall caused by missing ticks.

// File: rtl/phase_recal_pkg.sv
// Shared types for the phase offset recalibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package phase_recal_pkg;

    // Sequencer states, in the order they are walked
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLD    = 3'd1,
        ST_RAMP_DN = 3'd2,
        ST_DIV_RST = 3'd3,
        ST_RAMP_UP = 3'd4,
        ST_EXIT    = 3'd5
    } recal_state_e;

endpackage

// File: rtl/offset_ramp.sv
// Ramp generator for the applied phase offset.
// While track is high the output loads the target every cycle. While move
// is high it steps toward the target by min(distance, step) per cycle and
// lands exactly on it. A step of zero is treated as one.
// Assumes: STEP_W < OFS_W, values are two's complement.
module offset_ramp #(
    parameter int OFS_W  = 16,
    parameter int STEP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             track,
    input  logic             move,
    input  logic [OFS_W-1:0] target,
    input  logic [STEP_W-1:0] step,
    output logic [OFS_W-1:0] cur,
    output logic             at_target
);
    localparam int DW = OFS_W + 1;

    logic signed [DW-1:0] diff;
    logic [DW-1:0]        mag;
    logic [STEP_W-1:0]    step_eff;
    logic [OFS_W-1:0]     step_ext;

    // Distance and direction to the target, with one guard bit
    always_comb begin
        step_eff  = (step == '0) ? STEP_W'(1) : step;
        step_ext  = {{(OFS_W-STEP_W){1'b0}}, step_eff};
        diff      = $signed({target[OFS_W-1], target}) - $signed({cur[OFS_W-1], cur});
        mag       = diff[DW-1] ? DW'(-diff) : DW'(diff);
        at_target = (cur == target);
    end

    // Applied offset register: follow, step or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (track) begin
            cur <= target;
        end else if (move && !at_target) begin
            if (mag <= {1'b0, step_ext})
                cur <= target;
            else if (diff[DW-1])
                cur <= cur - step_ext;
            else
                cur <= cur + step_ext;
        end
    end
endmodule

// File: rtl/recal_ctrl.sv
// Sequencing state machine for phase offset recalibration.
// Walks hold entry, ramp to zero, divider reset, ramp to the latched offset
// and hold exit, and owns the self-clearing control bit.
// Assumes: at_target comes from the ramp generator and is combinational
// on the target this block presents.
module recal_ctrl
    import phase_recal_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             recal_wr,
    input  logic             recal_wdata,
    input  logic [OFS_W-1:0] offset_reg,
    input  logic             tick,
    input  logic             at_target,
    output logic [OFS_W-1:0] ramp_target,
    output logic             ramp_track,
    output logic             ramp_move,
    output logic             recal_bit,
    output logic             busy,
    output logic             hold_req,
    output logic             div_rst
);
    recal_state_e     state_q, state_d;
    logic [OFS_W-1:0] saved_q;

    // Next-state decision for the sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (recal_wr && recal_wdata) state_d = ST_HOLD;
            ST_HOLD:    state_d = ST_RAMP_DN;
            ST_RAMP_DN: if (at_target) state_d = ST_DIV_RST;
            ST_DIV_RST: state_d = ST_RAMP_UP;
            ST_RAMP_UP: if (at_target) state_d = ST_EXIT;
            ST_EXIT:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State, control bit and latched offset registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            recal_bit <= 1'b0;
            saved_q   <= '0;
        end else begin
            state_q   <= state_d;
            recal_bit <= (state_d != ST_IDLE);
            if (state_q == ST_IDLE)
                saved_q <= offset_reg;
        end
    end

    // Output decode and ramp target selection
    always_comb begin
        busy        = (state_q != ST_IDLE);
        hold_req    = (state_q == ST_HOLD) || (state_q == ST_RAMP_DN) ||
                      (state_q == ST_DIV_RST) || (state_q == ST_RAMP_UP);
        div_rst     = (state_q == ST_DIV_RST);
        ramp_track  = (state_q == ST_IDLE);
        ramp_move   = tick && ((state_q == ST_RAMP_DN) || (state_q == ST_RAMP_UP));
        unique case (state_q)
            ST_IDLE:              ramp_target = offset_reg;
            ST_RAMP_UP, ST_EXIT:  ramp_target = saved_q;
            default:              ramp_target = '0;
        endcase
    end
endmodule

// File: rtl/phase_recal_seq.sv
// Top of the phase offset recalibration sequencer: joins the state machine
// to the offset ramp generator.
// Assumes: one clock domain; tick is a synchronous enable in that domain.
module phase_recal_seq #(
    parameter int OFS_W  = 16,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              recal_wr,
    input  logic              recal_wdata,
    input  logic [OFS_W-1:0]  offset_reg,
    input  logic [STEP_W-1:0] step_size,
    input  logic              tick,
    output logic              recal_bit,
    output logic              busy,
    output logic              hold_req,
    output logic              div_rst,
    output logic [OFS_W-1:0]  phase_ofs
);
    logic [OFS_W-1:0] ramp_target;
    logic             ramp_track;
    logic             ramp_move;
    logic             at_target;

    recal_ctrl #(.OFS_W(OFS_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .recal_wr    (recal_wr),
        .recal_wdata (recal_wdata),
        .offset_reg  (offset_reg),
        .tick        (tick),
        .at_target   (at_target),
        .ramp_target (ramp_target),
        .ramp_track  (ramp_track),
        .ramp_move   (ramp_move),
        .recal_bit   (recal_bit),
        .busy        (busy),
        .hold_req    (hold_req),
        .div_rst     (div_rst)
    );

    offset_ramp #(.OFS_W(OFS_W), .STEP_W(STEP_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .track     (ramp_track),
        .move      (ramp_move),
        .target    (ramp_target),
        .step      (step_size),
        .cur       (phase_ofs),
        .at_target (at_target)
    );
endmodule

// File: rtl/phase_recal_seq_chk.sv
// Cycle-level checker for the recalibration sequencer, bound to the top.
// Assumes: same parameters as the bound instance.
module phase_recal_seq_chk #(
    parameter int OFS_W  = 16,
    parameter int STEP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              recal_wr,
    input logic              recal_wdata,
    input logic [STEP_W-1:0] step_size,
    input logic              tick,
    input logic              recal_bit,
    input logic              busy,
    input logic              hold_req,
    input logic              div_rst,
    input logic [OFS_W-1:0]  phase_ofs
);
    logic [OFS_W-1:0]     prev_ofs;
    logic [STEP_W-1:0]    prev_step;
    logic signed [OFS_W:0] dlt;
    logic [OFS_W:0]       dmag;
    logic [OFS_W:0]       lim;

    // Previous-cycle copies for the step bound
    always_ff @(posedge clk) begin
        prev_ofs  <= phase_ofs;
        prev_step <= step_size;
    end

    // Size of the last phase change
    always_comb begin
        dlt  = $signed({phase_ofs[OFS_W-1], phase_ofs}) - $signed({prev_ofs[OFS_W-1], prev_ofs});
        dmag = dlt[OFS_W] ? (OFS_W+1)'(-dlt) : (OFS_W+1)'(dlt);
        lim  = (prev_step == '0) ? (OFS_W+1)'(1) : (OFS_W+1)'(prev_step);
    end

    a_r5_div_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |=> !div_rst);
    a_r5_div_at_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |-> (hold_req && phase_ofs == '0));
    a_r7_bit_matches_busy: assert property (@(posedge clk) disable iff (!rst_n)
        recal_bit == busy);
    a_r6_hold_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |-> busy);
    a_r6_release_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hold_req) |=> !busy);
    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && recal_wr && recal_wdata) |=> (busy && hold_req));
    a_r4_stall_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && !tick) |=> $stable(phase_ofs));
    a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && tick) |=> (dmag <= lim));
endmodule

bind phase_recal_seq phase_recal_seq_chk #(.OFS_W(OFS_W), .STEP_W(STEP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .recal_wr    (recal_wr),
    .recal_wdata (recal_wdata),
    .step_size   (step_size),
    .tick        (tick),
    .recal_bit   (recal_bit),
    .busy        (busy),
    .hold_req    (hold_req),
    .div_rst     (div_rst),
    .phase_ofs   (phase_ofs)
);

// File: tb/phase_recal_seq_bench.sv
// Self-checking bench: a vector table of offset/step/expected length,
// then directed tests for reset, mid-run writes, offset change and tick gaps.
module phase_recal_seq_bench;
    localparam int OFS_W  = 16;
    localparam int STEP_W = 8;
    localparam int NV     = 7;

    // Table: programmed offset, step, expected busy length with tick=1
    localparam logic [OFS_W-1:0]  V_OFS  [NV] = '{16'd10, 16'hFFF9, 16'd0, 16'd100, 16'd5, 16'd20, 16'h8000};
    localparam logic [STEP_W-1:0] V_STEP [NV] = '{8'd3, 8'd2, 8'd5, 8'd100, 8'd0, 8'd7, 8'd255};
    localparam int                V_LEN  [NV] = '{13, 13, 5, 7, 15, 11, 263};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              recal_wr = 1'b0;
    logic              recal_wdata = 1'b0;
    logic [OFS_W-1:0]  offset_reg = '0;
    logic [STEP_W-1:0] step_size = 8'd1;
    logic              tick = 1'b1;
    logic              recal_bit, busy, hold_req, div_rst;
    logic [OFS_W-1:0]  phase_ofs;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    phase_recal_seq #(.OFS_W(OFS_W), .STEP_W(STEP_W)) u_phase_recal_seq (
        .clk(clk), .rst_n(rst_n), .recal_wr(recal_wr), .recal_wdata(recal_wdata),
        .offset_reg(offset_reg), .step_size(step_size), .tick(tick),
        .recal_bit(recal_bit), .busy(busy), .hold_req(hold_req),
        .div_rst(div_rst), .phase_ofs(phase_ofs)
    );

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sx(input logic [OFS_W-1:0] v);
        return int'($signed(v));
    endfunction

    // Start a sequence and follow it; writes/offset change/tick gap injectable
    task automatic run_seq(input int exp_len, input int exp_final,
                           input int wr_at, input int ofs_at, input logic [OFS_W-1:0] ofs_new,
                           input int gap_at);
        int len = 0, divs = 0, holds = 0, bad_step = 0, bad_stall = 0, bad_bit = 0;
        int div_ph = 0, lim, prev, d;
        logic last_hold = 1'b1;
        int last_ph = 0;
        lim  = (step_size == 0) ? 1 : int'(step_size);
        prev = sx(phase_ofs);
        recal_wr = 1'b1; recal_wdata = 1'b1;
        @(negedge clk);
        recal_wr = 1'b0;
        check("R3 start busy", busy && hold_req && recal_bit, busy, 1);
        while (busy && len < 2000) begin
            len++;
            d = sx(phase_ofs) - prev;
            if (d < 0) d = -d;
            if (tick && d > lim) bad_step++;
            if (!tick && d != 0) bad_stall++;
            if (recal_bit != busy) bad_bit++;
            if (div_rst) begin divs++; div_ph = sx(phase_ofs); end
            if (hold_req) holds++;
            last_hold = hold_req;
            last_ph   = sx(phase_ofs);
            prev      = sx(phase_ofs);
            recal_wr = 1'b0;
            if (wr_at >= 0 && len == wr_at)     begin recal_wr = 1'b1; recal_wdata = 1'b1; end
            if (wr_at >= 0 && len == wr_at + 2) begin recal_wr = 1'b1; recal_wdata = 1'b0; end
            if (len == ofs_at) offset_reg = ofs_new;
            tick = !(gap_at >= 0 && len >= gap_at && len < gap_at + 3);
            @(negedge clk);
        end
        recal_wr = 1'b0; tick = 1'b1;
        check("R7 busy length", len == exp_len, len, exp_len);
        check("R5 single divider strobe", divs == 1, divs, 1);
        check("R5 strobe at zero phase", div_ph == 0, div_ph, 0);
        check("R4 step bound", bad_step == 0, bad_step, 0);
        check("R4 stall without tick", bad_stall == 0, bad_stall, 0);
        check("R6 hold all but last", holds == len - 1 && !last_hold, holds, len - 1);
        check("R6 final offset restored", last_ph == exp_final, last_ph, exp_final);
        check("R7 bit tracks busy", bad_bit == 0 && !recal_bit, bad_bit, 0);
    endtask

    // Watchdog: a hung run is a failure but still reaches the summary
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        offset_reg = 16'd33;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", !busy && !recal_bit && !hold_req && !div_rst, busy, 0);
        check("R1 reset phase", phase_ofs == '0, sx(phase_ofs), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle follows offset", sx(phase_ofs) == 33 && !hold_req, sx(phase_ofs), 33);

        // R3: a write of 0 while idle starts nothing
        recal_wr = 1'b1; recal_wdata = 1'b0;
        @(negedge clk);
        recal_wr = 1'b0;
        check("R3 zero write no start", !busy && !recal_bit, busy, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            offset_reg = V_OFS[i];
            step_size  = V_STEP[i];
            @(negedge clk);
            check("R2 idle follows offset", phase_ofs == V_OFS[i], sx(phase_ofs), sx(V_OFS[i]));
            run_seq(V_LEN[i], sx(V_OFS[i]), -1, -1, '0, -1);
            @(negedge clk);
        end

        // R8: writes of 1 and 0 while busy are ignored
        offset_reg = 16'd10; step_size = 8'd1;
        @(negedge clk);
        run_seq(25, 10, 6, -1, '0, -1);
        repeat (3) @(negedge clk);
        check("R8 no deferred restart", !busy && !recal_bit, busy, 0);

        // R9: offset change mid-run does not move the second ramp's target
        run_seq(25, 10, -1, 4, 16'd50, -1);
        @(negedge clk);
        check("R9 new offset after finish", sx(phase_ofs) == 50, sx(phase_ofs), 50);

        // R4: tick gap stalls the ramp for three cycles
        offset_reg = 16'd10;
        @(negedge clk);
        run_seq(28, 10, -1, -1, '0, 3);

        // R1: reset aborts a running sequence
        recal_wr = 1'b1; recal_wdata = 1'b1;
        @(negedge clk);
        recal_wr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset aborts", !busy && !hold_req && !recal_bit && phase_ofs == '0, busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule